// File: doc/BRIEF.md
# Fractional Audio Bit-Clock Divider

This block derives a serial-audio bit clock from a fast reference clock. The divide ratio has a 10-bit whole part and a 9-bit fraction counted in 1/512 steps. The output frequency is the reference divided by two and then by (whole + fraction/512). The design does not use a plain integer counter. A phase accumulator decides whether each half-period of the output lasts the whole count or one cycle longer. A toggle stage flips the output at the end of every half-period, which gives the final divide by two. Software chooses the whole part so that the bit clock comes close to sample rate × 2 channels × sample width.

Configuration uses a small write-only register port with two words: the whole count, and the fraction together with an output-enable bit. When the audio port runs as a clock follower, the block clears the enable and keeps it clear, so it drives no bit clock. The block also brings out a one-cycle strobe that marks the last reference cycle of every half-period. Changes to the ratio or the enable take effect only at a half-period boundary, so the output never shows a shortened level.

Top module: `frac_bclk_div`

## Requirements
- R1: While reset is asserted, and after reset until the output is enabled, `bclk` and `bclk_stb` are low, and the whole, fraction and enable fields are zero.
- R2: A write with `cfg_sel`=0 loads the whole count from `cfg_wdata[9:0]`. A write with `cfg_sel`=1 loads the fraction from `cfg_wdata[8:0]` and the enable from `cfg_wdata[31]`. All other data bits are ignored.
- R3: While the enable is clear, or the whole count is zero, no half-period starts and `bclk` stays low.
- R4: The accumulator is 9 bits wide and restarts at zero each time the clock starts. At the start of every half-period it adds the fraction. That half-period lasts the whole count in reference cycles, plus one cycle when the addition carries past 511. The first half-period (low) therefore lasts exactly the whole count.
- R5: `bclk` changes only at the end of a half-period. `bclk_stb` is high for exactly one reference cycle per half-period, in its last cycle.
- R6: Over 512 consecutive half-periods that follow the first, the total length is 512 × whole + fraction cycles.
- R7: After a write that sets the enable while the whole count W is nonzero, `bclk` first rises W+1 cycles after the write edge.
- R8: A new whole count or fraction written during a half-period does not change that half-period. It applies from the next one on.
- R9: When the enable is cleared or the whole count is set to zero while running, the current half-period completes at full length. `bclk` is low from that boundary on.
- R10: While `clk_follower` is high, the enable is cleared and writes cannot set it. The enable stays clear after `clk_follower` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 whole count, 1 fraction and enable |
| cfg_wdata | input | 32 | Register write data |
| clk_follower | input | 1 | High when the audio port takes its clock from outside |
| bclk | output | 1 | Generated bit clock |
| bclk_stb | output | 1 | Last cycle of the current half-period |

## Verification
Assertions check on every cycle that the output is low whenever the divider is not running, and that it changes only right after a strobe. They also check that the active half-period length never changes inside a half-period, that a strobe seen with the enable clear leaves the output low and stopped, and that follower mode clears the enable. The bench scenarios cover what needs counting or history: the exact half-period lengths the accumulator produces, the 512-half-period total, the start latency, the ignored data bits, and ratio changes applied at a boundary.

// File: rtl/bclk_frac_pkg.sv
package bclk_frac_pkg;
  localparam int unsigned WHOLE_W_DFLT  = 10;
  localparam int unsigned FRAC_W_DFLT   = 9;
  localparam int unsigned DATA_W_DFLT   = 32;
  localparam int unsigned EN_BIT_DFLT   = 31;

  typedef enum logic {
    SEL_WHOLE = 1'b0,
    SEL_FRAC  = 1'b1
  } bclk_sel_e;
endpackage

// File: rtl/bclk_cfg_regs.sv
module bclk_cfg_regs
  import bclk_frac_pkg::*;
#(
  parameter int unsigned WHOLE_W = WHOLE_W_DFLT,
  parameter int unsigned FRAC_W  = FRAC_W_DFLT,
  parameter int unsigned DATA_W  = DATA_W_DFLT,
  parameter int unsigned EN_BIT  = EN_BIT_DFLT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic               sel_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               follower_i,
  output logic [WHOLE_W-1:0] whole_o,
  output logic [FRAC_W-1:0]  frac_o,
  output logic               en_o
);
  logic [WHOLE_W-1:0] whole_q;
  logic [FRAC_W-1:0]  frac_q;
  logic               en_q;
  logic               wr_whole, wr_frac;
  logic               unused_wdata;

  assign wr_whole     = wr_i && (bclk_sel_e'(sel_i) == SEL_WHOLE);
  assign wr_frac      = wr_i && (bclk_sel_e'(sel_i) == SEL_FRAC);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      whole_q <= '0;
      frac_q  <= '0;
      en_q    <= 1'b0;
    end else begin
      if (wr_whole) whole_q <= wdata_i[WHOLE_W-1:0];
      if (wr_frac)  frac_q  <= wdata_i[FRAC_W-1:0];
      if (follower_i)   en_q <= 1'b0;
      else if (wr_frac) en_q <= wdata_i[EN_BIT];
    end
  end

  assign whole_o = whole_q;
  assign frac_o  = frac_q;
  assign en_o    = en_q;

  // R10
  follower_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    follower_i |=> !en_q);
endmodule

// File: rtl/bclk_phase_core.sv
module bclk_phase_core #(
  parameter int unsigned WHOLE_W = 10,
  parameter int unsigned FRAC_W  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WHOLE_W-1:0] whole_i,
  input  logic [FRAC_W-1:0]  frac_i,
  input  logic               en_i,
  output logic               stb_o,
  output logic               toggle_o,
  output logic               stop_o,
  output logic               run_o
);
  localparam int unsigned LEN_W  = WHOLE_W + 1;
  localparam int unsigned STEP_W = LEN_W + FRAC_W;

  // Length of the next half-period and the accumulator value after it.
  function automatic logic [STEP_W-1:0] half_step(
    input logic [WHOLE_W-1:0] whole,
    input logic [FRAC_W-1:0]  acc,
    input logic [FRAC_W-1:0]  frac
  );
    logic [FRAC_W:0]  sum;
    logic [LEN_W-1:0] len;
    sum = {1'b0, acc} + {1'b0, frac};
    len = {1'b0, whole} + LEN_W'(sum[FRAC_W]);
    return {len, sum[FRAC_W-1:0]};
  endfunction

  logic [LEN_W-1:0]  cnt_q, len_q;
  logic [FRAC_W-1:0] acc_q;
  logic              run_q;
  logic              cfg_ok, start_w;
  logic [STEP_W-1:0] step_first, step_next;

  assign cfg_ok     = en_i && (whole_i != '0);
  assign step_first = half_step(whole_i, '0, frac_i);
  assign step_next  = half_step(whole_i, acc_q, frac_i);
  assign stb_o      = run_q && (cnt_q == len_q);
  assign toggle_o   = stb_o && cfg_ok;
  assign stop_o     = stb_o && !cfg_ok;
  assign start_w    = !run_q && cfg_ok;
  assign run_o      = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      len_q <= '0;
      acc_q <= '0;
    end else if (start_w) begin
      run_q          <= 1'b1;
      cnt_q          <= LEN_W'(1);
      {len_q, acc_q} <= step_first;
    end else if (toggle_o) begin
      cnt_q          <= LEN_W'(1);
      {len_q, acc_q} <= step_next;
    end else if (stop_o) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      len_q <= '0;
      acc_q <= '0;
    end else if (run_q) begin
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end

  // R8
  len_held_in_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && $past(run_q) && !$past(stb_o) |-> $stable(len_q));
endmodule

// File: rtl/bclk_toggle.sv
module bclk_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle_i,
  input  logic stop_i,
  output logic bclk_o
);
  logic bclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        bclk_q <= 1'b0;
    else if (stop_i)   bclk_q <= 1'b0;
    else if (toggle_i) bclk_q <= ~bclk_q;
  end

  assign bclk_o = bclk_q;
endmodule

// File: rtl/frac_bclk_div.sv
module frac_bclk_div
  import bclk_frac_pkg::*;
#(
  parameter int unsigned WHOLE_W = WHOLE_W_DFLT,
  parameter int unsigned FRAC_W  = FRAC_W_DFLT,
  parameter int unsigned DATA_W  = DATA_W_DFLT,
  parameter int unsigned EN_BIT  = EN_BIT_DFLT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              clk_follower,
  output logic              bclk,
  output logic              bclk_stb
);
  logic [WHOLE_W-1:0] cfg_whole;
  logic [FRAC_W-1:0]  cfg_frac;
  logic               cfg_en;
  logic               core_stb, core_toggle, core_stop, core_run;

  bclk_cfg_regs #(
    .WHOLE_W(WHOLE_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W), .EN_BIT(EN_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr), .sel_i(cfg_sel),
    .wdata_i(cfg_wdata), .follower_i(clk_follower),
    .whole_o(cfg_whole), .frac_o(cfg_frac), .en_o(cfg_en)
  );

  bclk_phase_core #(.WHOLE_W(WHOLE_W), .FRAC_W(FRAC_W)) u_core (
    .clk(clk), .rst_n(rst_n), .whole_i(cfg_whole), .frac_i(cfg_frac),
    .en_i(cfg_en), .stb_o(core_stb), .toggle_o(core_toggle),
    .stop_o(core_stop), .run_o(core_run)
  );

  bclk_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .toggle_i(core_toggle), .stop_i(core_stop),
    .bclk_o(bclk)
  );

  assign bclk_stb = core_stb;

  // R3
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_run |-> !bclk);

  // R5
  edge_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bclk) |-> $past(bclk_stb));

  // R9
  stop_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_stb && !cfg_en |=> !bclk && !core_run);
endmodule

// File: tb/test_frac_bclk_div.sv
module test_frac_bclk_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        clk_follower = 1'b0;
  logic        bclk, bclk_stb;
  int          n_chk = 0;
  int          n_err = 0;

  always #4 clk = ~clk;

  frac_bclk_div i_frac_bclk_div (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .clk_follower(clk_follower),
    .bclk(bclk), .bclk_stb(bclk_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench model of one accumulator step: returns half length, updates acc.
  function automatic int model_half(input int whole, input int frac, inout int acc);
    int s;
    s   = acc + frac;
    acc = s % 512;
    return whole + ((s >= 512) ? 1 : 0);
  endfunction

  // Called at a negedge; the write is sampled at the next posedge.
  task automatic wr(input bit sel, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    while (!bclk && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure_half(output int n, output int s);
    logic prev;
    prev = bclk; n = 0; s = 0;
    do begin
      s += int'(bclk_stb);
      @(negedge clk);
      n++;
    end while (bclk == prev && n < 5000);
  endtask

  task automatic check_idle(input int cycles, input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (bclk || bclk_stb) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic stop_clock(input int whole);
    wr(1'b1, 32'h0);
    repeat (2 * whole + 4) @(negedge clk);
    check_idle(8, "R9 idle after stop");
  endtask

  // Start with given ratio, check latency (R7) and a run of halves (R4, R5).
  task automatic run_trial(input int whole, input int frac, input int halves,
                           input string tag);
    int acc, n, s, exp, bad_len, bad_stb;
    wr(1'b0, 32'(whole));
    wr(1'b1, 32'h8000_0000 | 32'(frac));
    wait_rise(n);
    chk(n == whole + 1, "R7 start latency", n, whole + 1);
    acc = 0;
    void'(model_half(whole, frac, acc));
    bad_len = 0; bad_stb = 0;
    for (int k = 0; k < halves; k++) begin
      exp = model_half(whole, frac, acc);
      measure_half(n, s);
      if (n != exp) begin
        bad_len++;
        $display("FAIL R4 %s half %0d actual=%0d expected=%0d", tag, k, n, exp);
      end
      if (s != 1) bad_stb++;
    end
    chk(bad_len == 0, "R4 half lengths", bad_len, 0);
    chk(bad_stb == 0, "R5 one strobe per half", bad_stb, 0);
    stop_clock(whole + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int n, s, acc, exp, total, w, f;
    void'($urandom(32'd7731));
    repeat (3) @(negedge clk);
    chk(!bclk && !bclk_stb, "R1 reset outputs", int'(bclk), 0);
    rst_n = 1'b1;
    check_idle(10, "R1 idle after reset");

    // R3: enable with zero whole count
    wr(1'b1, 32'h8000_0011);
    check_idle(30, "R3 zero whole count");
    wr(1'b1, 32'h0);

    // R2: ignored data bits
    run_trial(3, 5, 12, "R2");
    wr(1'b0, 32'hFFFF_FC04);
    wr(1'b1, 32'hFFFF_FE07);
    wait_rise(n);
    chk(n == 5, "R2 masked fields latency", n, 5);
    stop_clock(5);

    // Directed corners
    run_trial(1, 0, 20, "div1");
    run_trial(1, 511, 30, "frac511");
    run_trial(1023, 256, 4, "maxwhole");

    // Randomized ratios
    for (int t = 0; t < 6; t++) begin
      w = 1 + int'($urandom % 12);
      f = int'($urandom % 512);
      run_trial(w, f, 24, "rand");
    end

    // R6: long-run average
    f = 1 + int'($urandom % 510);
    wr(1'b0, 32'd2);
    wr(1'b1, 32'h8000_0000 | 32'(f));
    wait_rise(n);
    total = 0;
    for (int k = 0; k < 512; k++) begin
      measure_half(n, s);
      total += n;
    end
    chk(total == 512 * 2 + f, "R6 total over 512 halves", total, 512 * 2 + f);
    stop_clock(3);

    // R8: change of whole count mid half-period
    wr(1'b0, 32'd4);
    wr(1'b1, 32'h8000_0000 | 32'd100);
    wait_rise(n);
    acc = 0;
    void'(model_half(4, 100, acc));
    exp = model_half(4, 100, acc);
    fork
      wr(1'b0, 32'd7);
      measure_half(n, s);
    join
    chk(n == exp, "R8 current half keeps old ratio", n, exp);
    exp = model_half(7, 100, acc);
    measure_half(n, s);
    chk(n == exp, "R8 next half uses new ratio", n, exp);
    exp = model_half(7, 100, acc);
    // R9: clear enable at the start of a half; that half completes
    fork
      wr(1'b1, 32'd100);
      measure_half(n, s);
    join
    chk(n == exp, "R9 final half full length", n, exp);
    chk(!bclk, "R9 output low after stop", int'(bclk), 0);
    check_idle(20, "R9 stays idle");

    // R9: whole count set to zero while running
    wr(1'b1, 32'h8000_0000);
    wait_rise(n);
    wr(1'b0, 32'd0);
    repeat (12) @(negedge clk);
    check_idle(20, "R9 stop on zero whole");

    // R10: follower mode
    clk_follower = 1'b1;
    wr(1'b0, 32'd5);
    wr(1'b1, 32'h8000_0003);
    check_idle(25, "R10 enable blocked");
    clk_follower = 1'b0;
    check_idle(25, "R10 enable stays clear");
    wr(1'b1, 32'h8000_0003);
    wait_rise(n);
    chk(n == 6, "R10 restart after follower", n, 6);
    clk_follower = 1'b1;
    repeat (16) @(negedge clk);
    clk_follower = 1'b0;
    check_idle(25, "R10 follower stops clock");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule